// File: doc/BRIEF.md
# Three-Class QoS Request Arbiter

This block decides, each cycle, which of three request queues feeding one memory controller is served next. The queues carry latency-sensitive, bandwidth-sensitive and insensitive traffic, and each one presents only a head-valid flag. If a single queue has work, it is served on every cycle in which the downstream side is ready. If two or three queues have work, a bounded priority scheme is used. The latency-sensitive queue first gets a quota of grants. The two lower classes then take turns. When the bandwidth-sensitive queue gets its turn, it may keep the grant for a short burst.

The quota (M) and the burst length (N) are run-time inputs, normally driven from a configuration register. A value of zero removes that phase. One quota-plus-turn cycle is called a round. A round ends when the insensitive queue is granted or when a bandwidth burst finishes, and the quota is then reloaded. This keeps a busy lower class from starving the latency-sensitive queue for more than one turn. The output is a one-hot grant plus a 2-bit class code. At most one grant is issued per cycle, and it is combinational from the current request flags and the arbiter state.

Top module: `qos_arb`

## Requirements
- R1: When exactly one queue is valid and `ready_i` is high, that queue is granted in that cycle. A grant never goes to a queue whose valid bit is low.
- R2: No grant is issued while `ready_i` is low, and the arbiter state does not advance in such cycles. `gnt_valid_o` is high exactly when a grant is issued.
- R3: Grant encoding: bit 0 of `req_valid_i` and `gnt_o` is latency-sensitive, bit 1 is bandwidth-sensitive and bit 2 is insensitive. `gnt_o` is one-hot or zero, `gnt_class_o` equals the index of the granted bit, and `gnt_class_o` is 0 when there is no grant.
- R4: Under contention (two or more queues valid), the latency-sensitive queue wins while it has received fewer than `lat_quota_i` grants in the current round.
- R5: Once the quota is used up, the lower classes alternate, one turn each. After reset the bandwidth-sensitive class takes the first turn. If only one lower class is valid, it takes the turn.
- R6: A bandwidth-sensitive turn under contention lasts up to `bw_burst_i` back-to-back grants; a value of 0 or 1 gives a single grant.
- R7: If the bandwidth-sensitive queue empties in the middle of a burst while contention persists, the burst ends and the insensitive queue is served next.
- R8: With `lat_quota_i` equal to 0, the latency-sensitive queue is never granted while contention lasts.
- R9: The latency quota restarts after each lower-class turn, that is, after an insensitive grant or the end of a bandwidth burst.
- R10: The latency quota restarts whenever contention ends, meaning at most one queue is valid.
- R11: Reset clears the quota count and the burst, and points the turn pointer at the bandwidth-sensitive class. While no request is valid, all grant outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 3 | Head-valid flag of each class queue |
| ready_i | input | 1 | Downstream can accept a request this cycle |
| lat_quota_i | input | CNT_W | Latency-class grants per round under contention (M) |
| bw_burst_i | input | CNT_W | Maximum bandwidth-class burst length (N) |
| gnt_o | output | 3 | One-hot grant |
| gnt_valid_o | output | 1 | A grant is issued this cycle |
| gnt_class_o | output | 2 | Class code of the grant |

## Verification
Two events can land on the same cycle: the bandwidth queue running dry in the middle of a burst, and the turn handover to the insensitive class. The bench provokes this by giving the bandwidth queue fewer entries than the burst length while latency and insensitive requests remain pending. It then checks that the insensitive class is granted on the very next grant and that the latency quota is reloaded afterwards. A second overlap comes from contention ending on the same cycle as a quota count. This is judged by draining one episode and then opening a new one without reset: the new episode must give the full quota again.

// File: rtl/qos_arb_pkg.sv
package qos_arb_pkg;
  localparam int unsigned NUM_CLS = 3;

  typedef enum logic [1:0] {
    CLS_LAT = 2'd0,
    CLS_BW  = 2'd1,
    CLS_INS = 2'd2
  } qos_cls_e;
endpackage

// File: rtl/qos_arb_contend.sv
module qos_arb_contend #(
  parameter int unsigned N_REQ = 3
) (
  input  logic [N_REQ-1:0] valid_i,
  output logic             any_o,
  output logic             contend_o
);
  localparam int unsigned CW = $clog2(N_REQ + 1);

  logic [CW-1:0] pop;

  always_comb begin
    pop = '0;
    for (int k = 0; k < int'(N_REQ); k++) begin
      pop = pop + CW'(valid_i[k]);
    end
  end

  assign any_o     = |valid_i;
  assign contend_o = pop >= CW'(2);
endmodule

// File: rtl/qos_arb_lat_quota.sv
module qos_arb_lat_quota #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             contend_i,
  input  logic             lat_fire_i,
  input  logic             turn_end_i,
  input  logic [CNT_W-1:0] quota_i,
  output logic             open_o
);
  logic [CNT_W-1:0] used_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      used_q <= '0;
    end else if (!contend_i || turn_end_i) begin
      used_q <= '0;
    end else if (lat_fire_i && (used_q != '1)) begin
      used_q <= used_q + CNT_W'(1);
    end
  end

  assign open_o = used_q < quota_i;
endmodule

// File: rtl/qos_arb_lower_rr.sv
module qos_arb_lower_rr #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             contend_i,
  input  logic             bw_valid_i,
  input  logic             bw_fire_i,
  input  logic             ins_fire_i,
  input  logic [CNT_W-1:0] burst_len_i,
  output logic             burst_hold_o,
  output logic             prefer_ins_o,
  output logic             turn_end_o
);
  logic [CNT_W-1:0] left_q;
  logic             ptr_q;
  logic             active;
  logic             last_bw;
  logic             early_end;
  logic [CNT_W-1:0] first_left;

  assign active     = left_q != '0;
  assign first_left = (burst_len_i > CNT_W'(1)) ? burst_len_i - CNT_W'(1) : '0;
  assign last_bw    = bw_fire_i && (active ? (left_q == CNT_W'(1))
                                           : (burst_len_i <= CNT_W'(1)));
  assign early_end  = contend_i && active && !bw_valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      left_q <= '0;
      ptr_q  <= 1'b0;
    end else if (!contend_i) begin
      left_q <= '0;
    end else if (bw_fire_i) begin
      left_q <= active ? left_q - CNT_W'(1) : first_left;
      if (last_bw) ptr_q <= 1'b1;
    end else if (ins_fire_i) begin
      left_q <= '0;
      ptr_q  <= 1'b0;
    end else if (early_end) begin
      left_q <= '0;
      ptr_q  <= 1'b1;
    end
  end

  assign burst_hold_o = contend_i && active && bw_valid_i;
  assign prefer_ins_o = ptr_q;
  assign turn_end_o   = last_bw || ins_fire_i || early_end;
endmodule

// File: rtl/qos_arb.sv
module qos_arb
  import qos_arb_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       req_valid_i,
  input  logic             ready_i,
  input  logic [CNT_W-1:0] lat_quota_i,
  input  logic [CNT_W-1:0] bw_burst_i,
  output logic [2:0]       gnt_o,
  output logic             gnt_valid_o,
  output logic [1:0]       gnt_class_o
);
  logic     any_req;
  logic     contend;
  logic     lat_open;
  logic     burst_hold;
  logic     prefer_ins;
  logic     turn_end;
  logic     fire;
  qos_cls_e sel;

  qos_arb_contend #(.N_REQ(NUM_CLS)) u_contend (
    .valid_i   (req_valid_i),
    .any_o     (any_req),
    .contend_o (contend)
  );

  always_comb begin
    sel = CLS_LAT;
    if (!contend) begin
      if (req_valid_i[CLS_LAT])     sel = CLS_LAT;
      else if (req_valid_i[CLS_BW]) sel = CLS_BW;
      else                          sel = CLS_INS;
    end else if (burst_hold) begin
      sel = CLS_BW;
    end else if (req_valid_i[CLS_LAT] && lat_open) begin
      sel = CLS_LAT;
    end else if (req_valid_i[CLS_BW] && req_valid_i[CLS_INS]) begin
      sel = prefer_ins ? CLS_INS : CLS_BW;
    end else if (req_valid_i[CLS_BW]) begin
      sel = CLS_BW;
    end else begin
      sel = CLS_INS;
    end
  end

  assign fire = ready_i && any_req;

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_gnt
    assign gnt_o[g] = fire && (sel == qos_cls_e'(g));
  end

  assign gnt_valid_o = fire;
  assign gnt_class_o = fire ? sel : 2'd0;

  qos_arb_lat_quota #(.CNT_W(CNT_W)) u_quota (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .contend_i  (contend),
    .lat_fire_i (contend && gnt_o[CLS_LAT]),
    .turn_end_i (turn_end),
    .quota_i    (lat_quota_i),
    .open_o     (lat_open)
  );

  qos_arb_lower_rr #(.CNT_W(CNT_W)) u_lower (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .contend_i    (contend),
    .bw_valid_i   (req_valid_i[CLS_BW]),
    .bw_fire_i    (contend && gnt_o[CLS_BW]),
    .ins_fire_i   (contend && gnt_o[CLS_INS]),
    .burst_len_i  (bw_burst_i),
    .burst_hold_o (burst_hold),
    .prefer_ins_o (prefer_ins),
    .turn_end_o   (turn_end)
  );
endmodule

// File: rtl/qos_arb_chk.sv
module qos_arb_chk #(
  parameter int unsigned CNT_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [2:0]       req_valid_i,
  input logic             ready_i,
  input logic [CNT_W-1:0] lat_quota_i,
  input logic [CNT_W-1:0] bw_burst_i,
  input logic [2:0]       gnt_o,
  input logic             gnt_valid_o,
  input logic [1:0]       gnt_class_o
);
  logic           contend;
  logic [CNT_W:0] bw_run_q;
  logic [CNT_W:0] bw_cap;

  assign contend = $countones(req_valid_i) >= 2;
  assign bw_cap  = (bw_burst_i <= CNT_W'(1)) ? (CNT_W+1)'(1) : {1'b0, bw_burst_i};

  // consecutive bandwidth grants within one contended stretch
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bw_run_q <= '0;
    end else if (!contend || lat_quota_i == '0) begin
      bw_run_q <= '0;
    end else if (gnt_o[1]) begin
      if (bw_run_q != '1) bw_run_q <= bw_run_q + 1'b1;
    end else if (gnt_valid_o) begin
      bw_run_q <= '0;
    end
  end

  assert_ready_gate_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> (gnt_o == 3'b000 && !gnt_valid_o));

  assert_onehot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o) && (gnt_valid_o == (gnt_o != 3'b000)));

  assert_class_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gnt_valid_o |-> (gnt_o == (3'b001 << gnt_class_o)));

  assert_lone_queue_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_i && $countones(req_valid_i) == 1) |-> (gnt_o == req_valid_i));

  assert_grant_valid_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_o & ~req_valid_i) == 3'b000);

  assert_no_lat_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (contend && lat_quota_i == '0) |-> !gnt_o[0]);

  assert_burst_cap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bw_run_q <= bw_cap);
endmodule

bind qos_arb qos_arb_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .ready_i     (ready_i),
  .lat_quota_i (lat_quota_i),
  .bw_burst_i  (bw_burst_i),
  .gnt_o       (gnt_o),
  .gnt_valid_o (gnt_valid_o),
  .gnt_class_o (gnt_class_o)
);

// File: tb/qos_arb_test.sv
module qos_arb_test;
  localparam int CNT_W = 4;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [2:0]       req_valid = '0;
  logic             ready = 1'b1;
  logic [CNT_W-1:0] lat_quota = '0;
  logic [CNT_W-1:0] bw_burst = '0;
  logic [2:0]       gnt_o;
  logic             gnt_valid_o;
  logic [1:0]       gnt_class_o;

  typedef struct {
    logic [1:0] cls;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cnt[3];
  bit   done = 1'b0;

  always #5 clk = ~clk;

  qos_arb #(.CNT_W(CNT_W)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid),
    .ready_i     (ready),
    .lat_quota_i (lat_quota),
    .bw_burst_i  (bw_burst),
    .gnt_o       (gnt_o),
    .gnt_valid_o (gnt_valid_o),
    .gnt_class_o (gnt_class_o)
  );

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // monitor: pops expected grants and compares
  always @(negedge clk) begin
    #2;
    if (rst_ni && !done) begin
      if (!ready) check(gnt_o == 3'b000 && !gnt_valid_o, "R2", "grant while not ready", int'(gnt_o), 0);
      if (gnt_valid_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1", "unexpected grant class", int'(gnt_class_o), -1);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(gnt_class_o == e.cls, e.tag, "grant class", int'(gnt_class_o), int'(e.cls));
          check(gnt_o == (3'b001 << e.cls), "R3", "one-hot grant", int'(gnt_o), int'(3'b001 << e.cls));
        end
      end
    end
  end

  task automatic push_seq(string s, string tag);
    for (int k = 0; k < s.len(); k++) begin
      exp_t e;
      e.tag = tag;
      case (s[k])
        "L": begin e.cls = 2'd0; exp_q.push_back(e); end
        "B": begin e.cls = 2'd1; exp_q.push_back(e); end
        "I": begin e.cls = 2'd2; exp_q.push_back(e); end
        default: ;
      endcase
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni    = 1'b0;
    req_valid = '0;
    ready     = 1'b1;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic drain(int l, int b, int i, int m, int n, bit toggle, string seq, string tag);
    push_seq(seq, tag);
    cnt[0] = l; cnt[1] = b; cnt[2] = i;
    lat_quota = CNT_W'(m);
    bw_burst  = CNT_W'(n);
    for (int cyc = 0; cyc < 400 && (cnt[0] + cnt[1] + cnt[2]) > 0; cyc++) begin
      @(negedge clk);
      req_valid = {cnt[2] > 0, cnt[1] > 0, cnt[0] > 0};
      ready     = toggle ? (cyc % 2 == 0) : 1'b1;
      #1;
      if (gnt_valid_o && gnt_class_o < 2'd3) cnt[gnt_class_o]--;
    end
    @(negedge clk);
    req_valid = '0;
    ready     = 1'b1;
    #3;
    check(exp_q.size() == 0, tag, "expected grants left", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    do_reset();
    // R11: idle after reset
    #3;
    check(gnt_o == 3'b000 && !gnt_valid_o && gnt_class_o == 2'd0, "R11", "idle outputs after reset",
          int'({gnt_valid_o, gnt_class_o, gnt_o}), 0);

    // R1: lone queue served each cycle
    drain(0, 3, 0, 2, 2, 1'b0, "BBB", "R1");

    // R4 R5 R6 R11: full three-class contention, quota 2, burst 3
    do_reset();
    drain(10, 10, 10, 2, 3, 1'b0, "LLBBBLLI LLBBBLLI LLBBBIB IIIIIII", "R4_R5_R6");

    // R8: quota 0, burst 0
    do_reset();
    drain(3, 2, 2, 0, 0, 1'b0, "BIBILLL", "R8");

    // R7: bandwidth queue empties mid-burst
    do_reset();
    drain(3, 2, 3, 1, 4, 1'b0, "LBBILILI", "R7");

    // R9: quota reload after insensitive turn
    do_reset();
    drain(5, 0, 2, 3, 1, 1'b0, "LLLILLI", "R9");

    // R2: ready toggling holds order
    do_reset();
    drain(2, 2, 1, 1, 2, 1'b1, "LBBLI", "R2");

    // R10: contention ends, new episode gets full quota
    do_reset();
    drain(1, 1, 0, 2, 1, 1'b0, "LB", "R10");
    drain(2, 1, 0, 2, 1, 1'b0, "LLB", "R10");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run hung actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule